// File: doc/BRIEF.md
# Windowed Layer Alpha Blender

This block lays one display layer over a lower colour inside a programmable rectangle of the scan. The timing generator supplies the current column and line, already expressed in accumulated-timing coordinates. The layer supplies one packed pixel and a code that says how it is packed. The configuration supplies the window bounds, an enable, an 8-bit constant alpha, two blend-factor selects and a 24-bit background colour. A select input chooses the lower colour. It is either the background colour or the output of a layer below, arriving on its own input.

Inside the window, with the layer enabled, each colour channel becomes a weighted sum of the layer channel and the lower channel. The weights come from the constant alpha, or from the product of pixel alpha and constant alpha. In every other case the lower colour passes through unchanged. The result is registered twice, so it appears a fixed two clocks after its inputs.

Top module: `win_alpha_blender`

## Requirements
- R1: A pixel is inside the window when winHStart <= pixX <= winHStop and winVStart <= pixY <= winVStop, with all four bounds inclusive. The bounds are given in accumulated-timing space, so a visible column x0 is programmed as x0 + 1 + accumulated horizontal back porch, and lines are programmed the same way.
- R2: When layerOn is 0, outPix equals the lower colour, whatever the layer pixel, window or factors are.
- R3: The lower colour is lowerPix when lowerSel is 1 and bgColor when it is 0. Both are packed with red in 23:16, green in 15:8 and blue in 7:0, and outPix uses the same packing.
- R4: The layerFmt codes decode as follows. 0 is ARGB8888 (A 31:24, R 23:16, G 15:8, B 7:0). 1 is RGB888 (R 23:16, G 15:8, B 7:0). 2 is RGB565 (R 15:11, G 10:5, B 4:0). 3 is ARGB1555 (A 15, R 14:10, G 9:5, B 4:0). 4 is ARGB4444 (A 15:12, R 11:8, G 7:4, B 3:0). Codes 5 to 7 decode as code 0. Formats without an alpha field use alpha 255, and a 1-bit alpha maps to 0 or 255.
- R5: A narrow channel widens to 8 bits by repeating its top bits below itself: v5 becomes {v5, v5[4:2]}, v6 becomes {v6, v6[5:4]} and v4 becomes {v4, v4}.
- R6: Factor 1 equals constAlpha when f1Sel is 4. Any other code, 6 included, gives P = (pixelAlpha*constAlpha + 127) / 255.
- R7: Factor 2 equals 255 - constAlpha when f2Sel is 5. Any other code, 7 included, gives 255 - P.
- R8: Inside the window with the layer enabled, each channel is min(255, (F1*layer + F2*lower + 127) / 255). With constAlpha 255 and codes 4 and 5 this gives the layer colour; with constAlpha 0 it gives the lower colour.
- R9: Inputs sampled at one rising edge appear on outPix after the second rising edge. While rstN is low, outPix is 0.
- R10: Outside the window, with the layer enabled, outPix equals the lower colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixX | input | 12 | Current column, accumulated-timing space |
| pixY | input | 11 | Current line, accumulated-timing space |
| layerPixel | input | 32 | Packed layer pixel |
| layerFmt | input | 3 | Packing code of layerPixel |
| layerOn | input | 1 | Layer enable |
| winHStart | input | 12 | First column of the window, inclusive |
| winHStop | input | 12 | Last column of the window, inclusive |
| winVStart | input | 11 | First line of the window, inclusive |
| winVStop | input | 11 | Last line of the window, inclusive |
| constAlpha | input | 8 | Constant alpha, 255 meaning 1.0 |
| f1Sel | input | 3 | Factor 1 select |
| f2Sel | input | 3 | Factor 2 select |
| bgColor | input | 24 | Background colour |
| lowerPix | input | 24 | Output of the layer below |
| lowerSel | input | 1 | Lower colour source select |
| outPix | output | 24 | Blended RGB pixel |

## Verification
The first pattern scans every column and line across all four window edges, one step beyond each. This separates inclusive bounds from exclusive ones, and it separates the horizontal test from the vertical one. The second pattern steps through every packing code with varied pixel words, which exposes swapped field positions, wrong bit replication and a missing alpha default. The third pattern mixes factor codes: matched constant-alpha codes, product codes, and unlisted codes that must fall back to the product. A case with pixel alpha 0 and constant alpha 255 under mixed codes pushes the weighted sum past 255, so it tells saturation apart from wrap-around. The last pattern toggles the lower-colour source and disables the layer, which shows that the pass-through path takes the selected source.

// File: rtl/blend_pkg.sv
package blend_pkg;
  localparam int CH_W = 8;
  localparam int NUM_CH = 3;
  localparam int SUM_W = 2 * CH_W + 2;
  localparam logic [CH_W-1:0] FULL = 8'hFF;

  localparam logic [2:0] FMT_ARGB8888 = 3'd0;
  localparam logic [2:0] FMT_RGB888   = 3'd1;
  localparam logic [2:0] FMT_RGB565   = 3'd2;
  localparam logic [2:0] FMT_ARGB1555 = 3'd3;
  localparam logic [2:0] FMT_ARGB4444 = 3'd4;

  localparam logic [2:0] F1_CONST = 3'd4;
  localparam logic [2:0] F2_CONST = 3'd5;

  typedef struct packed {
    logic blendEn;
    logic f1Const;
    logic f2Const;
  } blend_strb_t;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [CH_W-1:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction
endpackage

// File: rtl/blend_ctrl.sv
module blend_ctrl
  import blend_pkg::*;
#(
  parameter int X_W = 12,
  parameter int Y_W = 11
) (
  input  logic [X_W-1:0] pixX,
  input  logic [Y_W-1:0] pixY,
  input  logic [X_W-1:0] winHStart,
  input  logic [X_W-1:0] winHStop,
  input  logic [Y_W-1:0] winVStart,
  input  logic [Y_W-1:0] winVStop,
  input  logic           layerOn,
  input  logic [2:0]     f1Sel,
  input  logic [2:0]     f2Sel,
  output blend_strb_t    strb
);
  logic inH, inV;

  // Inclusive bounds on both axes (R1)
  assign inH = (pixX >= winHStart) && (pixX <= winHStop);
  assign inV = (pixY >= winVStart) && (pixY <= winVStop);

  always_comb begin
    strb.blendEn = layerOn && inH && inV;
    strb.f1Const = (f1Sel == F1_CONST);
    strb.f2Const = (f2Sel == F2_CONST);
  end
endmodule

// File: rtl/blend_datapath.sv
module blend_datapath
  import blend_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  blend_strb_t           strb,
  input  logic [31:0]           layerPixel,
  input  logic [2:0]            layerFmt,
  input  logic [CH_W-1:0]       constAlpha,
  input  logic [NUM_CH*CH_W-1:0] lowerColor,
  output logic [NUM_CH*CH_W-1:0] outPix
);
  localparam int PROD_W = 2 * CH_W;

  logic [CH_W-1:0] pixA;
  logic [NUM_CH-1:0][CH_W-1:0] layerCh;
  logic [PROD_W-1:0] prodRaw;
  logic [CH_W-1:0] prodA, fac1, fac2;

  // Stage 1 registers
  logic s1Blend;
  logic [CH_W-1:0] s1F1, s1F2;
  logic [NUM_CH-1:0][CH_W-1:0] s1Layer;
  logic [NUM_CH-1:0][CH_W-1:0] s1Lower;
  logic [NUM_CH-1:0][CH_W-1:0] mixCh;

  // Format decode; channel index 2 = red, 1 = green, 0 = blue (R4, R5)
  always_comb begin
    pixA = layerPixel[31:24];
    layerCh[2] = layerPixel[23:16];
    layerCh[1] = layerPixel[15:8];
    layerCh[0] = layerPixel[7:0];
    case (layerFmt)
      FMT_RGB888: pixA = FULL;
      FMT_RGB565: begin
        pixA = FULL;
        layerCh[2] = widen5(layerPixel[15:11]);
        layerCh[1] = widen6(layerPixel[10:5]);
        layerCh[0] = widen5(layerPixel[4:0]);
      end
      FMT_ARGB1555: begin
        pixA = layerPixel[15] ? FULL : '0;
        layerCh[2] = widen5(layerPixel[14:10]);
        layerCh[1] = widen5(layerPixel[9:5]);
        layerCh[0] = widen5(layerPixel[4:0]);
      end
      FMT_ARGB4444: begin
        pixA = widen4(layerPixel[15:12]);
        layerCh[2] = widen4(layerPixel[11:8]);
        layerCh[1] = widen4(layerPixel[7:4]);
        layerCh[0] = widen4(layerPixel[3:0]);
      end
      default: ;
    endcase
  end

  // Factor selection (R6, R7)
  assign prodRaw = PROD_W'(pixA) * PROD_W'(constAlpha);
  assign prodA   = CH_W'((prodRaw + PROD_W'(127)) / PROD_W'(255));
  assign fac1    = strb.f1Const ? constAlpha : prodA;
  assign fac2    = strb.f2Const ? (FULL - constAlpha) : (FULL - prodA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Blend <= 1'b0;
      s1F1    <= '0;
      s1F2    <= '0;
      s1Layer <= '0;
      s1Lower <= '0;
    end else begin
      s1Blend <= strb.blendEn;
      s1F1    <= fac1;
      s1F2    <= fac2;
      s1Layer <= layerCh;
      s1Lower <= lowerColor;
    end
  end

  // Per-channel weighted sum, rounded divide, saturation (R8)
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SUM_W-1:0] wsum, quot;
    assign wsum = SUM_W'(s1F1) * SUM_W'(s1Layer[c]) +
                  SUM_W'(s1F2) * SUM_W'(s1Lower[c]) + SUM_W'(127);
    assign quot = wsum / SUM_W'(255);
    assign mixCh[c] = (quot > SUM_W'(255)) ? FULL : quot[CH_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outPix <= '0;
    else       outPix <= s1Blend ? mixCh : s1Lower;
  end

  // Stage 2 must forward the lower colour whenever stage 1 is not blending
  p_bypass_r10: assert property (@(posedge clk) disable iff (!rstN)
    !s1Blend |=> outPix == $past(s1Lower));
endmodule

// File: rtl/win_alpha_blender.sv
module win_alpha_blender
  import blend_pkg::*;
#(
  parameter int X_W = 12,
  parameter int Y_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [X_W-1:0] pixX,
  input  logic [Y_W-1:0] pixY,
  input  logic [31:0]    layerPixel,
  input  logic [2:0]     layerFmt,
  input  logic           layerOn,
  input  logic [X_W-1:0] winHStart,
  input  logic [X_W-1:0] winHStop,
  input  logic [Y_W-1:0] winVStart,
  input  logic [Y_W-1:0] winVStop,
  input  logic [7:0]     constAlpha,
  input  logic [2:0]     f1Sel,
  input  logic [2:0]     f2Sel,
  input  logic [23:0]    bgColor,
  input  logic [23:0]    lowerPix,
  input  logic           lowerSel,
  output logic [23:0]    outPix
);
  blend_strb_t strb;
  logic [23:0] lowerColor;

  assign lowerColor = lowerSel ? lowerPix : bgColor;  // R3

  blend_ctrl #(.X_W(X_W), .Y_W(Y_W)) u_ctrl (
    .pixX(pixX), .pixY(pixY),
    .winHStart(winHStart), .winHStop(winHStop),
    .winVStart(winVStart), .winVStop(winVStop),
    .layerOn(layerOn), .f1Sel(f1Sel), .f2Sel(f2Sel),
    .strb(strb)
  );

  blend_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .layerPixel(layerPixel), .layerFmt(layerFmt),
    .constAlpha(constAlpha), .lowerColor(lowerColor),
    .outPix(outPix)
  );

  p_off_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    !layerOn |=> ##1 outPix == $past(lowerSel ? lowerPix : bgColor, 2));

  p_outside_r10: assert property (@(posedge clk) disable iff (!rstN)
    (layerOn && (pixX < winHStart || pixX > winHStop))
      |=> ##1 outPix == $past(lowerSel ? lowerPix : bgColor, 2));

  p_full_alpha_r8: assert property (@(posedge clk) disable iff (!rstN)
    (layerOn && pixX >= winHStart && pixX <= winHStop &&
     pixY >= winVStart && pixY <= winVStop && layerFmt == 3'd1 &&
     f1Sel == 3'd4 && f2Sel == 3'd5 && constAlpha == 8'hFF)
      |=> ##1 outPix == $past(layerPixel[23:0], 2));

  p_zero_alpha_r6: assert property (@(posedge clk) disable iff (!rstN)
    (layerOn && pixX >= winHStart && pixX <= winHStop &&
     pixY >= winVStart && pixY <= winVStop &&
     f1Sel == 3'd4 && f2Sel == 3'd5 && constAlpha == 8'h00)
      |=> ##1 outPix == $past(lowerSel ? lowerPix : bgColor, 2));
endmodule

// File: tb/win_alpha_blender_test.sv
`timescale 1ns/1ps
module win_alpha_blender_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] pixX = '0, winHStart = '0, winHStop = '0;
  logic [10:0] pixY = '0, winVStart = '0, winVStop = '0;
  logic [31:0] layerPixel = '0;
  logic [2:0]  layerFmt = '0, f1Sel = 3'd6, f2Sel = 3'd7;
  logic        layerOn = 1'b0, lowerSel = 1'b0;
  logic [7:0]  constAlpha = 8'hFF;
  logic [23:0] bgColor = '0, lowerPix = '0;
  logic [23:0] outPix;

  int vectors = 0;
  int misses = 0;
  bit [31:0] seed = 32'h1234_5678;
  int expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;  // 250 MHz

  win_alpha_blender uut (
    .clk(clk), .rstN(rstN), .pixX(pixX), .pixY(pixY),
    .layerPixel(layerPixel), .layerFmt(layerFmt), .layerOn(layerOn),
    .winHStart(winHStart), .winHStop(winHStop),
    .winVStart(winVStart), .winVStop(winVStop),
    .constAlpha(constAlpha), .f1Sel(f1Sel), .f2Sel(f2Sel),
    .bgColor(bgColor), .lowerPix(lowerPix), .lowerSel(lowerSel),
    .outPix(outPix)
  );

  function automatic bit [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Behavioural reference built from the requirements
  function automatic int refModel();
    int lower, a, r, g, b, p, k1, k2, res, lc, cv;
    int pw;
    lower = lowerSel ? int'(lowerPix) : int'(bgColor);
    if (!layerOn || pixX < winHStart || pixX > winHStop ||
        pixY < winVStart || pixY > winVStop) return lower;
    pw = int'(layerPixel);
    case (layerFmt)
      3'd1: begin a = 255; r = (pw >> 16) & 255; g = (pw >> 8) & 255; b = pw & 255; end
      3'd2: begin
        a = 255;
        r = (pw >> 11) & 31; r = r * 8 + r / 4;
        g = (pw >> 5) & 63;  g = g * 4 + g / 16;
        b = pw & 31;         b = b * 8 + b / 4;
      end
      3'd3: begin
        a = ((pw >> 15) & 1) != 0 ? 255 : 0;
        r = (pw >> 10) & 31; r = r * 8 + r / 4;
        g = (pw >> 5) & 31;  g = g * 8 + g / 4;
        b = pw & 31;         b = b * 8 + b / 4;
      end
      3'd4: begin
        a = ((pw >> 12) & 15) * 17; r = ((pw >> 8) & 15) * 17;
        g = ((pw >> 4) & 15) * 17;  b = (pw & 15) * 17;
      end
      default: begin
        a = (pw >> 24) & 255; r = (pw >> 16) & 255; g = (pw >> 8) & 255; b = pw & 255;
      end
    endcase
    p  = (a * int'(constAlpha) + 127) / 255;
    k1 = (f1Sel == 3'd4) ? int'(constAlpha) : p;
    k2 = (f2Sel == 3'd5) ? 255 - int'(constAlpha) : 255 - p;
    res = 0;
    for (int c = 0; c < 3; c++) begin
      lc = (lower >> (8 * c)) & 255;
      cv = (c == 2) ? r : (c == 1) ? g : b;
      cv = (k1 * cv + k2 * lc + 127) / 255;
      if (cv > 255) cv = 255;
      res = res | (cv << (8 * c));
    end
    return res;
  endfunction

  task automatic tick();
    int e;
    string t;
    @(negedge clk);
    if (expQ.size() == 2) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      vectors++;
      if (int'(outPix) != e) begin
        misses++;
        $display("FAIL %s: outPix=%06h expected=%06h", t, outPix, e[23:0]);
      end
    end
  endtask

  task automatic push(input string tag);
    expQ.push_back(refModel());
    tagQ.push_back(tag);
  endtask

  task automatic flush();
    repeat (2) begin
      tick();
      if (expQ.size() == 1) begin
        expQ.push_back(refModel());
        tagQ.push_back("R9");
      end
    end
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #800000;
    misses++;
    $display("FAIL R9: watchdog expired, actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if (outPix != 24'h0) begin
        misses++;
        $display("FAIL R9: reset outPix=%06h expected=000000", outPix);
      end
    end
    rstN = 1'b1;
    winHStart = 12'd10; winHStop = 12'd20;
    winVStart = 11'd5;  winVStop = 11'd8;

    // R2: layer disabled, window covering the pixel
    for (int i = 0; i < 20; i++) begin
      tick();
      layerOn = 1'b0; pixX = 12'd12; pixY = 11'd6;
      layerPixel = nextRand(); bgColor = nextRand(); constAlpha = 8'hFF;
      f1Sel = 3'd4; f2Sel = 3'd5;
      push("R2");
    end
    flush();

    // R1 / R10: scan across all four window edges
    layerOn = 1'b1; f1Sel = 3'd6; f2Sel = 3'd7; layerFmt = 3'd0;
    for (int y = 4; y <= 9; y++) begin
      for (int x = 8; x <= 22; x++) begin
        tick();
        pixX = 12'(x); pixY = 11'(y);
        layerPixel = nextRand(); bgColor = nextRand(); constAlpha = 8'(nextRand());
        push((x >= 10 && x <= 20 && y >= 5 && y <= 8) ? "R1" : "R10");
      end
    end
    flush();

    // R4 / R5: every format code
    pixX = 12'd15; pixY = 11'd6;
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 12; i++) begin
        tick();
        layerFmt = 3'(f); layerPixel = nextRand(); bgColor = nextRand();
        constAlpha = (i < 4) ? 8'hFF : 8'(nextRand());
        push((f >= 2 && f <= 4) ? "R5" : "R4");
      end
    end
    flush();

    // R6: factor 1 codes, factor 2 held at its constant code
    layerFmt = 3'd0;
    for (int i = 0; i < 30; i++) begin
      tick();
      f1Sel = (i % 3 == 0) ? 3'd4 : (i % 3 == 1) ? 3'd6 : 3'd1;
      f2Sel = 3'd5;
      constAlpha = (i == 0) ? 8'h00 : (i == 3) ? 8'hFF : 8'(nextRand());
      layerPixel = nextRand(); bgColor = nextRand();
      push("R6");
    end
    // R7: factor 2 codes
    for (int i = 0; i < 30; i++) begin
      tick();
      f1Sel = 3'd6;
      f2Sel = (i % 3 == 0) ? 3'd5 : (i % 3 == 1) ? 3'd7 : 3'd2;
      constAlpha = 8'(nextRand()); layerPixel = nextRand(); bgColor = nextRand();
      push("R7");
    end
    flush();

    // R8: mixed codes that overflow and must saturate
    for (int i = 0; i < 20; i++) begin
      tick();
      f1Sel = 3'd4; f2Sel = 3'd7; constAlpha = 8'hFF;
      layerPixel = {8'h00, 24'(nextRand()) | 24'h808080};
      bgColor = 24'(nextRand()) | 24'hC0C0C0;
      push("R8");
    end
    flush();

    // R3: lower colour source select, inside and outside, layer on and off
    f1Sel = 3'd6; f2Sel = 3'd7;
    for (int i = 0; i < 24; i++) begin
      tick();
      lowerSel = i[0];
      layerOn = (i % 4) < 2;
      pixX = (i % 3 == 0) ? 12'd30 : 12'd14;
      lowerPix = nextRand(); bgColor = nextRand();
      layerPixel = nextRand(); constAlpha = 8'(nextRand());
      push("R3");
    end
    flush();

    finishRun();
  end
endmodule